// File: doc/BRIEF.md
# Control Register Unlock Sequencer

This block protects five configuration bits, a two-bit watchdog select and a three-bit block-protect field, that a serial bus master may only change through a fixed unlock sequence. The bit-level bus decoder in front of it delivers byte-level events: a transaction start (with its direction), received data bytes, and a transaction stop. For every byte of a write transaction the block answers with an acknowledge or a negative acknowledge, one cycle after the byte.

Two volatile latches gate the change. A single-byte write of 02h arms the write-enable latch. A single-byte write of 06h, given while that latch is set, also arms the register-write-enable latch. A third single-byte write then either commits new watchdog and block-protect values or leaves them alone and keeps the latches armed, depending on bit 2 of that byte. A commit starts a busy interval that stands in for the nonvolatile programming time. During that interval every byte is refused. A hardware lock, formed by an active-low pin together with a lock-enable input, refuses all register writes and drops both latches. Effects of a write transaction take hold at its stop event, so a transaction that carries a second byte has no effect at all.

Top module: `cru_unlock_seq`

## Requirements
- R1: After reset, wel_o, rwel_o, busy_o and ack_valid_o are 0 and wd_sel_o/bp_o hold the reset value (default all zero).
- R2: A write transaction whose only byte is 02h sets wel_o at its stop and does not raise busy_o.
- R3: A single-byte write of 06h sets rwel_o (with wel_o kept set) only if wel_o is already set; with wel_o clear it changes nothing; rwel_o is never 1 while wel_o is 0.
- R4: With rwel_o set, a single-byte write whose bit 7 is 0, bit 1 is 1 and bit 2 is 0 commits: wd_sel_o takes bits 6:5, bp_o[2] takes bit 4, bp_o[1] bit 3 and bp_o[0] bit 0; wel_o and rwel_o clear. The same byte given with rwel_o clear changes nothing, so the full sequence must be repeated.
- R5: With rwel_o set, a single-byte write with bit 7 = 0, bit 1 = 1 and bit 2 = 1 leaves wd_sel_o and bp_o unchanged and keeps rwel_o set (02h, 06h, 06h changes no configuration bit).
- R6: The sequence 02h, 06h, 02h clears wd_sel_o and bp_o to zero.
- R7: A commit raises busy_o from the cycle after the stop for exactly BUSY_CYCLES cycles; the configuration does not change while busy_o is high.
- R8: Any byte received while busy_o is high is answered with a NACK and changes no latch or configuration bit.
- R9: In a write transaction the first byte is ACKed; a second byte is NACKed and the whole transaction then has no effect at its stop.
- R10: Read transactions produce no acknowledge and leave wel_o, rwel_o and the configuration unchanged, so the sequence survives reads placed between its steps.
- R11: While wp_n_i is 0 and wp_lock_en_i is 1, write bytes are NACKed, wel_o and rwel_o clear and nothing commits; with wp_n_i at 1 or wp_lock_en_i at 0 the sequence works normally.
- R12: ack_valid_o pulses exactly once, in the cycle after each byte of a write transaction or each byte during busy, with ack_o = 1 for ACK and 0 for NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start_i | input | 1 | One-cycle pulse: transaction begins |
| txn_stop_i | input | 1 | One-cycle pulse: transaction ends |
| txn_read_i | input | 1 | Direction, sampled with txn_start_i (1 = read) |
| byte_valid_i | input | 1 | One-cycle pulse: byte_i carries a received byte |
| byte_i | input | 8 | Received data byte |
| wp_n_i | input | 1 | Hardware write-protect pin, active low |
| wp_lock_en_i | input | 1 | Enables the hardware lock |
| ack_valid_o | output | 1 | Acknowledge response valid |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| busy_o | output | 1 | Programming interval active |
| wel_o | output | 1 | Write-enable latch |
| rwel_o | output | 1 | Register-write-enable latch |
| wd_sel_o | output | 2 | Watchdog select bits |
| bp_o | output | 3 | Block-protect bits |

## Verification
The assertions watch, on every cycle, that the register-write latch never stands without the write latch, that the configuration only moves after a cycle with the register-write latch set and never while busy or hardware-locked, that a busy interval opens with both latches clear, and that bytes during busy or under the lock are refused. Only the bench's scenarios can show the sequence itself: that 02h/06h/commit orderings give the right field mapping, that the bit-2 re-arm keeps the old values, that reads in between leave the latches armed, that a two-byte write is discarded, and that the busy interval has its exact length.

// File: rtl/cru_pkg.sv
package cru_pkg;

    localparam int WD_BITS = 2;
    localparam int BP_BITS = 3;

    localparam logic [7:0] BYTE_ARM_WE  = 8'h02;
    localparam logic [7:0] BYTE_ARM_RWE = 8'h06;

    typedef struct packed {
        logic [WD_BITS-1:0] wd;
        logic [BP_BITS-1:0] bp;
    } cfg_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_SET_WE,
        ACT_SET_RWE,
        ACT_COMMIT
    } act_t;

    // Map a committed byte onto the configuration fields.
    function automatic cfg_t cfg_from_byte(input logic [7:0] b);
        cfg_t c;
        c.wd = b[6:5];
        c.bp = {b[4], b[3], b[0]};
        return c;
    endfunction

    // Decide what a lone write byte does given the current latches.
    function automatic act_t decode_byte(input logic [7:0] b,
                                         input logic we,
                                         input logic rwe);
        act_t a;
        a = ACT_NONE;
        if (rwe && !b[7] && b[1]) begin
            a = b[2] ? ACT_NONE : ACT_COMMIT;
        end else if (b == BYTE_ARM_WE) begin
            a = ACT_SET_WE;
        end else if (b == BYTE_ARM_RWE && we) begin
            a = ACT_SET_RWE;
        end
        return a;
    endfunction

endpackage

// File: rtl/cru_txn_tracker.sv
module cru_txn_tracker (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       rd_i,
    input  logic       byte_valid_i,
    input  logic [7:0] byte_i,
    input  logic       busy_i,
    input  logic       hwlock_i,
    output logic       ack_valid_o,
    output logic       ack_o,
    output logic       apply_o,
    output logic [7:0] apply_byte_o,
    output logic       lock_hit_o
);

    logic       in_wr;
    logic       have_byte;
    logic       aborted;
    logic [7:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_wr       <= 1'b0;
            have_byte   <= 1'b0;
            aborted     <= 1'b0;
            held        <= '0;
            ack_valid_o <= 1'b0;
            ack_o       <= 1'b0;
        end else begin
            ack_valid_o <= 1'b0;
            ack_o       <= 1'b0;
            if (start_i) begin
                in_wr     <= !rd_i && !busy_i;
                have_byte <= 1'b0;
                aborted   <= 1'b0;
            end else if (stop_i) begin
                in_wr     <= 1'b0;
                have_byte <= 1'b0;
                aborted   <= 1'b0;
            end
            if (byte_valid_i) begin
                if (busy_i) begin
                    ack_valid_o <= 1'b1;
                end else if (in_wr) begin
                    ack_valid_o <= 1'b1;
                    if (hwlock_i) begin
                        ack_o <= 1'b0;
                    end else if (!have_byte) begin
                        ack_o     <= 1'b1;
                        have_byte <= 1'b1;
                        held      <= byte_i;
                    end else begin
                        ack_o   <= 1'b0;
                        aborted <= 1'b1;
                    end
                end
            end
        end
    end

    assign apply_o      = stop_i && in_wr && have_byte && !aborted && !busy_i && !hwlock_i;
    assign apply_byte_o = held;
    assign lock_hit_o   = byte_valid_i && in_wr && !busy_i && hwlock_i;

endmodule

// File: rtl/cru_latches.sv
module cru_latches
    import cru_pkg::*;
#(
    parameter cfg_t RST_CFG = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       apply_i,
    input  logic [7:0] apply_byte_i,
    input  logic       lock_hit_i,
    output logic       wel_o,
    output logic       rwel_o,
    output cfg_t       cfg_o,
    output logic       commit_o
);

    act_t act;

    always_comb begin
        act      = decode_byte(apply_byte_i, wel_o, rwel_o);
        commit_o = apply_i && (act == ACT_COMMIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wel_o  <= 1'b0;
            rwel_o <= 1'b0;
            cfg_o  <= RST_CFG;
        end else if (lock_hit_i) begin
            wel_o  <= 1'b0;
            rwel_o <= 1'b0;
        end else if (apply_i) begin
            unique case (act)
                ACT_SET_WE:  wel_o <= 1'b1;
                ACT_SET_RWE: begin
                    wel_o  <= 1'b1;
                    rwel_o <= 1'b1;
                end
                ACT_COMMIT: begin
                    cfg_o  <= cfg_from_byte(apply_byte_i);
                    wel_o  <= 1'b0;
                    rwel_o <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cru_busy_timer.sv
module cru_busy_timer #(
    parameter int BUSY_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start_i) begin
            cnt <= CW'(BUSY_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy_o = (cnt != '0);

endmodule

// File: rtl/cru_unlock_seq.sv
module cru_unlock_seq
    import cru_pkg::*;
#(
    parameter int                 BUSY_CYCLES = 16,
    parameter logic [WD_BITS-1:0] RST_WD      = '0,
    parameter logic [BP_BITS-1:0] RST_BP      = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               txn_start_i,
    input  logic               txn_stop_i,
    input  logic               txn_read_i,
    input  logic               byte_valid_i,
    input  logic [7:0]         byte_i,
    input  logic               wp_n_i,
    input  logic               wp_lock_en_i,
    output logic               ack_valid_o,
    output logic               ack_o,
    output logic               busy_o,
    output logic               wel_o,
    output logic               rwel_o,
    output logic [WD_BITS-1:0] wd_sel_o,
    output logic [BP_BITS-1:0] bp_o
);

    localparam cfg_t RST_CFG = '{wd: RST_WD, bp: RST_BP};

    logic       hwlock;
    logic       apply;
    logic [7:0] apply_byte;
    logic       lock_hit;
    logic       commit;
    cfg_t       cfg;

    assign hwlock = !wp_n_i && wp_lock_en_i;

    cru_txn_tracker u_trk (
        .clk          (clk),
        .rst          (rst),
        .start_i      (txn_start_i),
        .stop_i       (txn_stop_i),
        .rd_i         (txn_read_i),
        .byte_valid_i (byte_valid_i),
        .byte_i       (byte_i),
        .busy_i       (busy_o),
        .hwlock_i     (hwlock),
        .ack_valid_o  (ack_valid_o),
        .ack_o        (ack_o),
        .apply_o      (apply),
        .apply_byte_o (apply_byte),
        .lock_hit_o   (lock_hit)
    );

    cru_latches #(.RST_CFG(RST_CFG)) u_lat (
        .clk          (clk),
        .rst          (rst),
        .apply_i      (apply),
        .apply_byte_i (apply_byte),
        .lock_hit_i   (lock_hit),
        .wel_o        (wel_o),
        .rwel_o       (rwel_o),
        .cfg_o        (cfg),
        .commit_o     (commit)
    );

    cru_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .start_i (commit),
        .busy_o  (busy_o)
    );

    assign wd_sel_o = cfg.wd;
    assign bp_o     = cfg.bp;

endmodule

// File: rtl/cru_unlock_seq_chk.sv
module cru_unlock_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       byte_valid_i,
    input logic       wp_n_i,
    input logic       wp_lock_en_i,
    input logic       ack_valid_o,
    input logic       ack_o,
    input logic       busy_o,
    input logic       wel_o,
    input logic       rwel_o,
    input logic [1:0] wd_sel_o,
    input logic [2:0] bp_o
);

    logic [4:0] cfg_w;
    assign cfg_w = {wd_sel_o, bp_o};

    p_rwel_needs_wel_r3: assert property (@(posedge clk) disable iff (rst)
        rwel_o |-> wel_o);

    p_cfg_needs_rwel_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rwel_o) |-> $stable(cfg_w));

    p_commit_drops_latches_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (!rwel_o && !wel_o));

    p_busy_freezes_cfg_r7: assert property (@(posedge clk) disable iff (rst)
        $past(busy_o) |-> $stable(cfg_w));

    p_busy_nack_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(busy_o) && $past(byte_valid_i)) |-> (ack_valid_o && !ack_o));

    p_lock_freezes_cfg_r11: assert property (@(posedge clk) disable iff (rst)
        $past(!wp_n_i && wp_lock_en_i) |-> $stable(cfg_w));

    p_lock_nack_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(byte_valid_i && !wp_n_i && wp_lock_en_i) && ack_valid_o) |-> !ack_o);

endmodule

bind cru_unlock_seq cru_unlock_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .byte_valid_i (byte_valid_i),
    .wp_n_i       (wp_n_i),
    .wp_lock_en_i (wp_lock_en_i),
    .ack_valid_o  (ack_valid_o),
    .ack_o        (ack_o),
    .busy_o       (busy_o),
    .wel_o        (wel_o),
    .rwel_o       (rwel_o),
    .wd_sel_o     (wd_sel_o),
    .bp_o         (bp_o)
);

// File: tb/cru_unlock_seq_test.sv
module cru_unlock_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       txn_start_i = 1'b0;
    logic       txn_stop_i = 1'b0;
    logic       txn_read_i = 1'b0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic       wp_n_i = 1'b1;
    logic       wp_lock_en_i = 1'b0;
    logic       ack_valid_o, ack_o, busy_o, wel_o, rwel_o;
    logic [1:0] wd_sel_o;
    logic [2:0] bp_o;

    int errors = 0;
    int checks = 0;
    int exp_q[$];
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cru_unlock_seq #(.BUSY_CYCLES(BUSY)) uut (.*);

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every acknowledge is matched against the queue.
    always @(negedge clk) begin
        if (!rst && ack_valid_o) begin
            if (exp_q.size() == 0) begin
                check("R12 unexpected ack", 1, 0);
            end else begin
                check("R12 ack value", int'(ack_o), exp_q.pop_front());
            end
        end
    end

    // Driver: one transaction of one or two bytes; e0/e1 = 1 ACK, 0 NACK, -1 none.
    task automatic txn(input bit rd, input int n, input logic [7:0] b0,
                       input int e0, input logic [7:0] b1, input int e1);
        @(negedge clk);
        txn_start_i = 1'b1; txn_read_i = rd;
        @(negedge clk);
        txn_start_i = 1'b0;
        byte_valid_i = 1'b1; byte_i = b0;
        if (e0 >= 0) exp_q.push_back(e0);
        if (n > 1) begin
            @(negedge clk);
            byte_i = b1;
            if (e1 >= 0) exp_q.push_back(e1);
        end
        @(negedge clk);
        byte_valid_i = 1'b0;
        txn_stop_i = 1'b1;
        @(negedge clk);
        txn_stop_i = 1'b0;
    endtask

    task automatic wr1(input logic [7:0] b, input int e);
        txn(1'b0, 1, b, e, 8'h00, -1);
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 wel", wel_o, 0);
        check("R1 rwel", rwel_o, 0);
        check("R1 busy", busy_o, 0);
        check("R1 ack_valid", ack_valid_o, 0);
        check("R1 cfg", {wd_sel_o, bp_o}, 0);

        // R3: 06h without write-enable does nothing
        wr1(8'h06, 1);
        check("R3 06h alone rwel", rwel_o, 0);
        check("R3 06h alone wel", wel_o, 0);

        // R2: 02h arms write-enable, no busy
        wr1(8'h02, 1);
        check("R2 wel", wel_o, 1);
        check("R2 no busy", busy_o, 0);

        // R10: read in between keeps state
        txn(1'b1, 2, 8'hA5, -1, 8'h5A, -1);
        check("R10 wel after read", wel_o, 1);
        wr1(8'h06, 1);
        check("R3 rwel", rwel_o, 1);
        check("R3 wel kept", wel_o, 1);
        txn(1'b1, 1, 8'h33, -1, 8'h00, -1);
        check("R10 rwel after read", rwel_o, 1);

        // R4: commit 0x53 -> wd=2, bp={1,0,1}=5
        wr1(8'h53, 1);
        check("R4 wd", wd_sel_o, 2);
        check("R4 bp", bp_o, 5);
        check("R4 wel cleared", wel_o, 0);
        check("R4 rwel cleared", rwel_o, 0);
        // R7 busy length
        cnt = 0;
        while (busy_o) begin cnt++; @(negedge clk); end
        check("R7 busy cycles", cnt, BUSY);

        // R4: commit byte without the sequence is ignored
        wr1(8'h13, 1);
        check("R4 no repeat wd", wd_sel_o, 2);
        check("R4 no repeat bp", bp_o, 5);
        check("R4 no repeat busy", busy_o, 0);

        // R5: 02h, 06h, 06h keeps config and rwel
        wr1(8'h02, 1);
        wr1(8'h06, 1);
        wr1(8'h06, 1);
        check("R5 wd", wd_sel_o, 2);
        check("R5 bp", bp_o, 5);
        check("R5 rwel", rwel_o, 1);
        check("R5 busy", busy_o, 0);

        // R6: ... then 02h clears all
        wr1(8'h02, 1);
        check("R6 cfg zero", {wd_sel_o, bp_o}, 0);
        check("R7 busy after commit", busy_o, 1);
        // R8: byte during busy NACKed, no effect
        wr1(8'h02, 0);
        check("R8 busy still", busy_o, 1);
        wait_idle();
        check("R8 wel unchanged", wel_o, 0);

        // R9: two bytes in one write transaction
        txn(1'b0, 2, 8'h02, 1, 8'h06, 0);
        check("R9 wel", wel_o, 0);
        check("R9 rwel", rwel_o, 0);

        // R11: hardware lock
        wr1(8'h02, 1);
        wr1(8'h06, 1);
        check("R11 armed", rwel_o, 1);
        wp_n_i = 1'b0; wp_lock_en_i = 1'b1;
        wr1(8'h53, 0);
        check("R11 cfg held", {wd_sel_o, bp_o}, 0);
        check("R11 rwel cleared", rwel_o, 0);
        check("R11 wel cleared", wel_o, 0);
        check("R11 no busy", busy_o, 0);
        wp_n_i = 1'b1;
        wr1(8'h02, 1);
        wr1(8'h06, 1);
        wr1(8'h53, 1);
        check("R11 pin high wd", wd_sel_o, 2);
        check("R11 pin high bp", bp_o, 5);
        wait_idle();
        wp_n_i = 1'b0; wp_lock_en_i = 1'b0;
        wr1(8'h02, 1);
        wr1(8'h06, 1);
        wr1(8'h02, 1);
        check("R11 enable low cfg", {wd_sel_o, bp_o}, 0);
        wait_idle();

        repeat (2) @(negedge clk);
        check("R12 queue drained", exp_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule